// File: doc/BRIEF.md
# Multiplexer Logic Cell with Latch-Pair Register

This block is a configurable logic cell assembled purely from two-input multiplexers. Each lane owns an A-path multiplexer choosing between two data inputs under its own select, a B-path multiplexer doing the same, and a final multiplexer whose select is the OR of two further select inputs. By tying data inputs to constants or to other signals, a lane realises AND, OR, XOR and many wider functions without a lookup table.

After the multiplexer tree sits an optional storage element. A master latch, open while the clock is low, feeds a slave latch, open while the clock is high, so the pair captures on the rising edge. An active-high asynchronous clear empties both latches. A mode bit picks whether the output shows the multiplexer result directly or the stored value. The cell is replicated `WIDTH` times with independent data and selects per lane and a shared clock, clear and mode.

Top module: `lm_cell`

## Requirements
- R1: In a lane where s0 and s1 are both 0, the combinational result equals a1 when sa is 1 and a0 when sa is 0.
- R2: In a lane where s0 or s1 is 1, the combinational result equals b1 when sb is 1 and b0 when sb is 0.
- R3: With mode 0, y follows the combinational result of every lane immediately, with no clock edge needed.
- R4: With mode 1 and clr low, after each rising clock edge y equals the combinational result present just before that edge.
- R5: With mode 1, input changes while the clock is high or low between rising edges leave y unchanged.
- R6: While clr is 1 the stored value is 0 in every lane, taking effect without a clock edge and holding across rising edges.
- R7: Per lane, sa=x, a0=0, a1=z, s0=s1=0 gives x AND z; sa=x, a0=z, a1=1 gives x OR z; sa=x, a0=z, a1=NOT z gives x XOR z.
- R8: Changing mode switches y between the combinational result and the stored value without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures into the register |
| clr | input | 1 | Asynchronous clear of the register, active high |
| mode | input | 1 | 0 = combinational output, 1 = registered output |
| a0 | input | WIDTH | A-path data chosen when sa is 0 |
| a1 | input | WIDTH | A-path data chosen when sa is 1 |
| b0 | input | WIDTH | B-path data chosen when sb is 0 |
| b1 | input | WIDTH | B-path data chosen when sb is 1 |
| sa | input | WIDTH | A-path select per lane |
| sb | input | WIDTH | B-path select per lane |
| s0 | input | WIDTH | Final select term, ORed with s1 |
| s1 | input | WIDTH | Final select term, ORed with s0 |
| y | output | WIDTH | Cell output |

## Verification
The hardest situation to reach is proving the latch pair is edge-triggered rather than merely transparent: the inputs must move while the clock is high, when only the slave is open, and again while it is low, when only the master is open, with y required to stay put both times. The bench drives such mid-phase changes explicitly, and likewise raises clr in the middle of a clock phase to show the clear acts without an edge, then runs edges under clear. Random per-lane selects cover both final-select paths in the same cycle across lanes.

// File: rtl/lm_pkg.sv
// Shared definitions for the multiplexer logic cell.
// Assumes: mode encoding is a single bit used by the top and checker.
package lm_pkg;
    typedef enum logic {
        LM_COMB = 1'b0,
        LM_REG  = 1'b1
    } lm_mode_e;
endpackage

// File: rtl/lm_mux2.sv
// Single-bit two-input multiplexer; the only logic primitive of the cell.
// Assumes: sel is a resolved 0/1 value.
module lm_mux2 (
    input  logic d0,
    input  logic d1,
    input  logic sel,
    output logic q
);
    // Select one of two data bits.
    always_comb begin
        q = sel ? d1 : d0;
    end
endmodule

// File: rtl/lm_mux_tree.sv
// Three-multiplexer tree per lane: A-path, B-path, and a final stage whose
// select is the OR of two select terms.
// Assumes: all lanes are independent; no storage inside.
module lm_mux_tree #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a0,
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] b0,
    input  logic [WIDTH-1:0] b1,
    input  logic [WIDTH-1:0] sa,
    input  logic [WIDTH-1:0] sb,
    input  logic [WIDTH-1:0] s0,
    input  logic [WIDTH-1:0] s1,
    output logic [WIDTH-1:0] f
);
    logic [WIDTH-1:0] a_path;
    logic [WIDTH-1:0] b_path;
    logic [WIDTH-1:0] fin_sel;

    // Gate logic on the last-stage select.
    always_comb begin
        fin_sel = s0 | s1;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        lm_mux2 u_amux (.d0(a0[i]), .d1(a1[i]), .sel(sa[i]), .q(a_path[i]));
        lm_mux2 u_bmux (.d0(b0[i]), .d1(b1[i]), .sel(sb[i]), .q(b_path[i]));
        lm_mux2 u_fmux (.d0(a_path[i]), .d1(b_path[i]), .sel(fin_sel[i]), .q(f[i]));
    end
endmodule

// File: rtl/lm_latch.sv
// Level-sensitive latch bank with asynchronous clear.
// Assumes: en is glitch-free; clr has priority over en.
module lm_latch #(
    parameter int WIDTH = 4
) (
    input  logic             en,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Transparent while en is high, holds otherwise, zero while clr.
    always_latch begin
        if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lm_msreg.sv
// Master-slave register from two latches: master open on clock low, slave
// open on clock high, giving rising-edge capture. Clear empties both.
// Assumes: d is stable around the rising edge.
module lm_msreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic             clk_low;
    logic [WIDTH-1:0] mst_q;

    // Inverted clock phase for the master latch.
    always_comb begin
        clk_low = ~clk;
    end

    lm_latch #(.WIDTH(WIDTH)) u_master (.en(clk_low), .clr(clr), .d(d),     .q(mst_q));
    lm_latch #(.WIDTH(WIDTH)) u_slave  (.en(clk),     .clr(clr), .d(mst_q), .q(q));
endmodule

// File: rtl/lm_cell.sv
// Multiplexer logic cell: mux tree followed by an optional latch-pair register.
// Assumes: mode selects the output path combinationally; clr is async, active high.
module lm_cell #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             mode,
    input  logic [WIDTH-1:0] a0,
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] b0,
    input  logic [WIDTH-1:0] b1,
    input  logic [WIDTH-1:0] sa,
    input  logic [WIDTH-1:0] sb,
    input  logic [WIDTH-1:0] s0,
    input  logic [WIDTH-1:0] s1,
    output logic [WIDTH-1:0] y
);
    import lm_pkg::*;

    logic [WIDTH-1:0] comb_f;
    logic [WIDTH-1:0] reg_q;

    lm_mux_tree #(.WIDTH(WIDTH)) u_tree (
        .a0(a0), .a1(a1), .b0(b0), .b1(b1),
        .sa(sa), .sb(sb), .s0(s0), .s1(s1), .f(comb_f)
    );

    lm_msreg #(.WIDTH(WIDTH)) u_reg (.clk(clk), .clr(clr), .d(comb_f), .q(reg_q));

    // Output path choice by mode.
    always_comb begin
        y = (lm_mode_e'(mode) == LM_REG) ? reg_q : comb_f;
    end
endmodule

// File: rtl/lm_cell_chk.sv
// Property checker for lm_cell, attached by bind.
// Assumes: clr is held high from time zero until the first edges pass.
module lm_cell_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             mode,
    input logic [WIDTH-1:0] a0,
    input logic [WIDTH-1:0] a1,
    input logic [WIDTH-1:0] b0,
    input logic [WIDTH-1:0] b1,
    input logic [WIDTH-1:0] sa,
    input logic [WIDTH-1:0] sb,
    input logic [WIDTH-1:0] s0,
    input logic [WIDTH-1:0] s1,
    input logic [WIDTH-1:0] y,
    input logic [WIDTH-1:0] reg_q
);
    logic [WIDTH-1:0] bsel;
    logic [WIDTH-1:0] apick;
    logic [WIDTH-1:0] bpick;
    logic [WIDTH-1:0] want;

    // Behavioural expectation from the port values.
    always_comb begin
        bsel  = s0 | s1;
        apick = (a1 & sa) | (a0 & ~sa);
        bpick = (b1 & sb) | (b0 & ~sb);
        want  = (apick & ~bsel) | (bpick & bsel);
    end

    AST_A_PATH: assert property (@(posedge clk) disable iff (clr)
        (mode == 1'b0) |-> (((y ^ apick) & ~bsel) == '0)); // R1
    AST_B_PATH: assert property (@(posedge clk) disable iff (clr)
        (mode == 1'b0) |-> (((y ^ bpick) & bsel) == '0)); // R2
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (clr)
        1'b1 |=> (reg_q == $past(want))); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk)
        clr |-> (reg_q == '0)); // R6
endmodule

bind lm_cell lm_cell_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .clr(clr), .mode(mode),
    .a0(a0), .a1(a1), .b0(b0), .b1(b1),
    .sa(sa), .sb(sb), .s0(s0), .s1(s1),
    .y(y), .reg_q(reg_q)
);

// File: tb/lm_cell_tb_top.sv
module lm_cell_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         mode = 1'b0;
    logic [W-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
    logic [W-1:0] sa = '0, sb = '0, s0 = '0, s1 = '0;
    logic [W-1:0] y;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] ref_q = '0;
    bit done = 0;

    lm_cell #(.WIDTH(W)) dut_i (
        .clk(clk), .clr(clr), .mode(mode),
        .a0(a0), .a1(a1), .b0(b0), .b1(b1),
        .sa(sa), .sb(sb), .s0(s0), .s1(s1), .y(y)
    );

    always #4 clk = ~clk;

    // Per-lane reference from the requirement text.
    function automatic logic [W-1:0] ref_fn();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (s0[i] || s1[i]) r[i] = sb[i] ? b1[i] : b0[i];
            else                r[i] = sa[i] ? a1[i] : a0[i];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One rising edge, updating the model, then settle 1 ns past the edge.
    task automatic tick();
        logic [W-1:0] cap;
        cap = ref_fn();
        @(posedge clk);
        if (!clr) ref_q = cap;
        #1;
    endtask

    function automatic logic [W-1:0] ref_y();
        return mode ? ref_q : ref_fn();
    endfunction

    task automatic rand_inputs();
        a0 = W'($urandom); a1 = W'($urandom); b0 = W'($urandom); b1 = W'($urandom);
        sa = W'($urandom); sb = W'($urandom); s0 = W'($urandom); s1 = W'($urandom);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state: clear held across edges, registered mode.
        mode = 1'b1;
        a0 = '1; a1 = '1; b0 = '1; b1 = '1;
        tick(); tick();
        check("R6 reset clear", y, '0);
        clr = 1'b0;
        #1;

        // R1 and R2: directed path selection in combinational mode.
        mode = 1'b0;
        a0 = 4'b0101; a1 = 4'b1010; b0 = 4'b0011; b1 = 4'b1100;
        sa = 4'b0000; s0 = '0; s1 = '0; #1;
        check("R1 sa=0 picks a0", y, 4'b0101);
        sa = 4'b1111; #1;
        check("R1 sa=1 picks a1", y, 4'b1010);
        s0 = 4'b1111; sb = 4'b0000; #1;
        check("R2 s0=1 sb=0 picks b0", y, 4'b0011);
        s0 = 4'b0000; s1 = 4'b1111; sb = 4'b1111; #1;
        check("R2 s1=1 sb=1 picks b1", y, 4'b1100);
        s0 = 4'b0101; s1 = 4'b0011; sb = 4'b0000; sa = 4'b0000; #1;
        check("R1 R2 mixed lanes", y, 4'b0011 & 4'b0111 | 4'b0101 & 4'b1000);

        // R3: combinational follow with no clock edge (clock low phase).
        @(negedge clk); #1;
        s0 = '0; s1 = '0; sa = '0; a0 = 4'b1001; #1;
        check("R3 follow without edge", y, 4'b1001);
        a0 = 4'b0110; #1;
        check("R3 follow second change", y, 4'b0110);

        // R7: gate realisations, all lane patterns of x and z.
        for (int p = 0; p < 4; p++) begin
            logic [W-1:0] x, z;
            x = 4'b1100; z = 4'b1010;
            if (p[0]) x = ~x;
            if (p[1]) z = ~z;
            s0 = '0; s1 = '0;
            sa = x; a0 = '0; a1 = z; #1;
            check("R7 AND", y, x & z);
            a0 = z; a1 = '1; #1;
            check("R7 OR", y, x | z);
            a0 = z; a1 = ~z; #1;
            check("R7 XOR", y, x ^ z);
        end

        // R4: registered capture under random stimulus.
        mode = 1'b1;
        for (int n = 0; n < 40; n++) begin
            rand_inputs();
            tick();
            check("R4 registered capture", y, ref_q);
        end

        // R5: inputs move in the high phase and then the low phase.
        rand_inputs(); tick();
        check("R5 captured", y, ref_q);
        a0 = ~a0; a1 = ~a1; b0 = ~b0; b1 = ~b1; #1;
        check("R5 stable clock high", y, ref_q);
        @(negedge clk); #1;
        a0 = ~a0; sa = ~sa; s0 = ~s0; #1;
        check("R5 stable clock low", y, ref_q);

        // R8: mode switch without an edge.
        mode = 1'b0; #1;
        check("R8 to combinational", y, ref_fn());
        mode = 1'b1; #1;
        check("R8 to registered", y, ref_q);

        // R6: mid-phase clear, then edges under clear.
        s0 = '0; s1 = '0; sa = '1; a1 = '1; tick();
        check("R6 loaded ones", y, '1);
        @(negedge clk); #1;
        clr = 1'b1; #1;
        check("R6 async clear", y, '0);
        tick(); tick();
        check("R6 held across edges", y, '0);
        @(negedge clk); #1;
        clr = 1'b0; #1;

        // Mixed random run, compared every clock.
        for (int n = 0; n < 300; n++) begin
            rand_inputs();
            mode = 1'($urandom);
            tick();
            check(mode ? "R4 random" : "R3 random", y, ref_y());
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule